// File: doc/BRIEF.md
# Keypad register and interrupt unit

This unit is the software-facing side of a matrix keypad controller. It holds the control fields for a separate scanner: enable, debounce count, start-up delay, repeat delay, and a wake mask for each row. It also queues the key snapshots that the scanner produces. Each snapshot holds up to eight 8-bit key entries. Software reads a snapshot as two 32-bit entry words. Reading the upper word retires that snapshot.

The queue occupancy can be read in the status word. A sticky threshold flag is set when the occupancy reaches a programmed threshold. That flag, gated by an interrupt enable, drives a level interrupt. The bus is a single-cycle 32-bit port with word addresses: word address = byte offset / 4. Read data is combinational from the address. Writes and pops take effect at the clock edge of the request.

Top module: `keypad_reg_unit`

## Requirements
- R1: After reset, the control, status and both entry words read 0, and `irq_o` is low.
- R2: The control word is at word 0 (byte 0x00). Its fields are run enable at bit 0, interrupt enable at bit 3, debounce count at bits 13:4 and threshold at bits 17:14. The other bits read 0. The fields drive `scan_en_o` and `debounce_o`.
- R3: Snapshots come out in arrival order. Entry word A is at word 12 (byte 0x30) and carries entries 0..3, with entry 0 in bits 7:0. Entry word B is at word 13 (byte 0x34) and carries entries 4..7. Entry bytes pass through unchanged; the scanner codes them as valid in bit 7, row in bits 6:3 and column in bits 2:0.
- R4: Reading entry word B retires the oldest snapshot. Reading entry word A does not. With the queue empty, both words read 0.
- R5: The status word is at word 1 (byte 0x04). Bits 7:4 give the queue occupancy, which is updated at the edge that accepts or retires a snapshot.
- R6: The queue holds 8 snapshots. A snapshot offered while the queue is full, with no retire in the same cycle, is dropped, and this sets the overflow flag at status bit 0.
- R7: With run enable set and a nonzero threshold, status bit 2 is set at the edge after the occupancy is at or above the threshold. `irq_o` is status bit 2 ANDed with the interrupt enable.
- R8: Writing ones to status bits 2:0 clears those flags, and zero bits leave them alone. If the set condition of a flag holds in the same cycle, the flag stays set.
- R9: Clearing run enable empties the queue at the next edge. Snapshots offered while run enable is low are ignored.
- R10: The start-up delay is a 20-bit register at word 10 (byte 0x28). The repeat delay is a 20-bit register at word 11 (byte 0x2C). Both read back with the upper bits 0 and drive `init_dly_o` and `repeat_dly_o`.
- R11: There is one wake mask per row, at word 14+r (byte 0x38+4r). Each mask is 8 bits and resets to 0. A cleared bit lets the key at that row and column wake the system. Row r appears on `wake_mask_o[8r+7:8r]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| snap_valid_i | input | 1 | Scanner offers a snapshot |
| snap_data_i | input | 64 | Eight entry bytes, entry 0 in bits 7:0 |
| irq_o | output | 1 | Level interrupt |
| scan_en_o | output | 1 | Run enable to the scanner |
| debounce_o | output | 10 | Debounce count |
| init_dly_o | output | 20 | Start-up delay |
| repeat_dly_o | output | 20 | Repeat delay |
| wake_mask_o | output | 128 | Wake masks for all rows, row r at bits 8r+7:8r |

## Verification
Each result is due at a fixed time after its stimulus:

- **Register write:** the read-back value and the control outputs change at the edge that takes the write.
- **Snapshot accept or retire:** the occupancy field changes at the edge that accepts or retires the snapshot.
- **Threshold flag:** the flag and `irq_o` follow one edge later than the occupancy change.
- **Queue flush:** the flush lands one edge after run enable is written low.

The bench drives every input just after a falling edge and samples just after the relevant rising edge. For the interrupt it checks in two places: that `irq_o` is still low right after the accepting edge, and that it is high after the next one. For the flush it waits one extra edge before reading the occupancy.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int A_CTRL    = 0;
  localparam int A_STAT    = 1;
  localparam int A_INIT    = 10;
  localparam int A_RPT     = 11;
  localparam int A_ENT_LO  = 12;
  localparam int A_ENT_HI  = 13;
  localparam int A_WAKE0   = 14;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_IRQEN_BIT = 3;
  localparam int CTRL_DEB_LSB   = 4;
  localparam int DEB_W          = 10;
  localparam int CTRL_THR_LSB   = 14;
  localparam int THR_W          = 4;

  localparam int STAT_OVF_BIT = 0;
  localparam int STAT_THR_BIT = 2;
  localparam int STAT_CNT_LSB = 4;
  localparam int STAT_CNT_W   = 4;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic [DEB_W-1:0] deb;
    logic             irq_en;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/kpd_snap_fifo.sv
module kpd_snap_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             do_push, do_pop;

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign head_o  = empty_o ? '0 : mem_q[rd_q];

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop)  rd_q <= inc(rd_q);
      if (do_push && !do_pop)      count_o <= count_o + 1'b1;
      else if (do_pop && !do_push) count_o <= count_o - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= data_i;
  end

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_o == '0);
  p_pop_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && pop_i && !push_i && !empty_o) |=> count_o == $past(count_o) - 1'b1);
  p_full_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && push_i && full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/kpd_irq_status.sv
module kpd_irq_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic       drop_i,
  input  logic       clr_en_i,
  input  logic [2:0] clr_bits_i,
  input  logic       irq_en_i,
  output logic       ovf_o,
  output logic       thr_o,
  output logic       irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      thr_o <= 1'b0;
    end else begin
      // set wins over a same-cycle clear
      if (drop_i)                         ovf_o <= 1'b1;
      else if (clr_en_i && clr_bits_i[0]) ovf_o <= 1'b0;
      if (hit_i)                          thr_o <= 1'b1;
      else if (clr_en_i && clr_bits_i[2]) thr_o <= 1'b0;
    end
  end

  assign irq_o = irq_en_i && thr_o;

  p_thr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> thr_o);
  p_ovf_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> ovf_o);
  p_clr_thr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && clr_bits_i[2] && !hit_i) |=> !thr_o);
endmodule

// File: rtl/keypad_reg_unit.sv
module keypad_reg_unit
  import kpd_pkg::*;
#(
  parameter int NUM_ROWS   = 16,
  parameter int NUM_COLS   = 8,
  parameter int ENTRIES    = 8,
  parameter int ENTRY_W    = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int DLY_W      = 20,
  parameter int ADDR_W     = 5,
  localparam int SNAP_W    = ENTRIES * ENTRY_W,
  localparam int ROW_W     = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bus_req_i,
  input  logic                         bus_we_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic [31:0]                  bus_wdata_i,
  output logic [31:0]                  bus_rdata_o,
  input  logic                         snap_valid_i,
  input  logic [SNAP_W-1:0]            snap_data_i,
  output logic                         irq_o,
  output logic                         scan_en_o,
  output logic [DEB_W-1:0]             debounce_o,
  output logic [DLY_W-1:0]             init_dly_o,
  output logic [DLY_W-1:0]             repeat_dly_o,
  output logic [NUM_ROWS*NUM_COLS-1:0] wake_mask_o
);
  ctrl_t             ctrl_q;
  logic [DLY_W-1:0]  init_q, rpt_q;
  logic [NUM_COLS-1:0] wake_q [NUM_ROWS];
  logic              wr, rd;
  logic              pop, push, drop, hit;
  logic [SNAP_W-1:0] head;
  logic [CNT_W-1:0]  count;
  logic              full, empty, ovf, thr_flag;
  logic [ADDR_W-1:0] wake_idx;
  logic              unused_bits;

  assign unused_bits = ^{bus_wdata_i[31:DLY_W], empty};

  assign wr = bus_req_i && bus_we_i;
  assign rd = bus_req_i && !bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      init_q <= '0;
      rpt_q  <= '0;
    end else if (wr) begin
      if (bus_addr_i == ADDR_W'(A_CTRL)) begin
        ctrl_q.en     <= bus_wdata_i[CTRL_EN_BIT];
        ctrl_q.irq_en <= bus_wdata_i[CTRL_IRQEN_BIT];
        ctrl_q.deb    <= bus_wdata_i[CTRL_DEB_LSB +: DEB_W];
        ctrl_q.thr    <= bus_wdata_i[CTRL_THR_LSB +: THR_W];
      end
      if (bus_addr_i == ADDR_W'(A_INIT)) init_q <= bus_wdata_i[DLY_W-1:0];
      if (bus_addr_i == ADDR_W'(A_RPT))  rpt_q  <= bus_wdata_i[DLY_W-1:0];
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_wake
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wake_q[r] <= '0;
      else if (wr && bus_addr_i == ADDR_W'(A_WAKE0 + r))
        wake_q[r] <= bus_wdata_i[NUM_COLS-1:0];
    end
    assign wake_mask_o[r*NUM_COLS +: NUM_COLS] = wake_q[r];
  end

  assign pop  = ctrl_q.en && rd && (bus_addr_i == ADDR_W'(A_ENT_HI));
  assign push = ctrl_q.en && snap_valid_i;
  assign drop = push && full && !(pop && count != '0);
  assign hit  = ctrl_q.en && (ctrl_q.thr != '0) && (int'(count) >= int'(ctrl_q.thr));

  kpd_snap_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SNAP_W)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!ctrl_q.en),
    .push_i  (push),
    .pop_i   (pop),
    .data_i  (snap_data_i),
    .head_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  kpd_irq_status i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .drop_i     (drop),
    .clr_en_i   (wr && bus_addr_i == ADDR_W'(A_STAT)),
    .clr_bits_i (bus_wdata_i[2:0]),
    .irq_en_i   (ctrl_q.irq_en),
    .ovf_o      (ovf),
    .thr_o      (thr_flag),
    .irq_o      (irq_o)
  );

  assign wake_idx = bus_addr_i - ADDR_W'(A_WAKE0);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(A_CTRL)) begin
      bus_rdata_o[CTRL_EN_BIT]                = ctrl_q.en;
      bus_rdata_o[CTRL_IRQEN_BIT]             = ctrl_q.irq_en;
      bus_rdata_o[CTRL_DEB_LSB +: DEB_W]      = ctrl_q.deb;
      bus_rdata_o[CTRL_THR_LSB +: THR_W]      = ctrl_q.thr;
    end else if (bus_addr_i == ADDR_W'(A_STAT)) begin
      bus_rdata_o[STAT_OVF_BIT]               = ovf;
      bus_rdata_o[STAT_THR_BIT]               = thr_flag;
      bus_rdata_o[STAT_CNT_LSB +: STAT_CNT_W] = STAT_CNT_W'(count);
    end else if (bus_addr_i == ADDR_W'(A_INIT)) begin
      bus_rdata_o[DLY_W-1:0] = init_q;
    end else if (bus_addr_i == ADDR_W'(A_RPT)) begin
      bus_rdata_o[DLY_W-1:0] = rpt_q;
    end else if (bus_addr_i == ADDR_W'(A_ENT_LO)) begin
      bus_rdata_o = head[31:0];
    end else if (bus_addr_i == ADDR_W'(A_ENT_HI)) begin
      bus_rdata_o = head[63:32];
    end else if (int'(bus_addr_i) >= A_WAKE0 && int'(bus_addr_i) < A_WAKE0 + NUM_ROWS) begin
      bus_rdata_o[NUM_COLS-1:0] = wake_q[wake_idx[ROW_W-1:0]];
    end
  end

  assign scan_en_o    = ctrl_q.en;
  assign debounce_o   = ctrl_q.deb;
  assign init_dly_o   = init_q;
  assign repeat_dly_o = rpt_q;

  p_disabled_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en) |=> count == '0);
  p_drop_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> count == CNT_W'(FIFO_DEPTH));
endmodule

// File: tb/test_keypad_reg_unit.sv
module test_keypad_reg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sv = 1'b0;
  logic [63:0] sdata = '0;
  logic        irq, scan_en;
  logic [9:0]  deb;
  logic [19:0] init_dly, rpt_dly;
  logic [127:0] wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keypad_reg_unit i_keypad_reg_unit (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .snap_valid_i(sv), .snap_data_i(sdata), .irq_o(irq),
    .scan_en_o(scan_en), .debounce_o(deb), .init_dly_o(init_dly),
    .repeat_dly_o(rpt_dly), .wake_mask_o(wake)
  );

  task automatic chk(input string req_id, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_id, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic push(input logic [63:0] d);
    @(negedge clk); sv = 1'b1; sdata = d;
    @(posedge clk); #1 sv = 1'b0;
  endtask

  function automatic logic [63:0] snap(input int k);
    return 64'h8899_AABB_CCDD_EE00 + 64'(k) * 64'h0101_0003_0105_0007;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(5'd0, d);  chk("R1 ctrl", d, 0);
    rd(5'd1, d);  chk("R1 stat", d, 0);
    rd(5'd12, d); chk("R1 entA", d, 0);
    rd(5'd13, d); chk("R1 entB", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_control;
    logic [31:0] d;
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, d); chk("R2 ctrl mask", d, 32'h0003_FFF9);
    chk("R2 debounce_o", deb, 10'h3FF);
    chk("R2 scan_en_o", scan_en, 1);
    wr(5'd0, 32'h0000_1230);
    rd(5'd0, d); chk("R2 ctrl value", d, 32'h0000_1230);
    chk("R2 debounce 0x123", deb, 10'h123);
    chk("R2 scan_en off", scan_en, 0);
  endtask

  task automatic t_delays;
    logic [31:0] d;
    wr(5'd10, 32'hFFFF_FFFF);
    rd(5'd10, d); chk("R10 init mask", d, 32'h000F_FFFF);
    wr(5'd11, 32'hABC1_2345);
    rd(5'd11, d); chk("R10 repeat", d, 32'h0001_2345);
    chk("R10 init_dly_o", init_dly, 20'hFFFFF);
    chk("R10 repeat_dly_o", rpt_dly, 20'h12345);
  endtask

  task automatic t_wake;
    logic [31:0] d;
    wr(5'd17, 32'h0000_00A5);
    wr(5'd29, 32'h0000_0FFF);
    rd(5'd17, d); chk("R11 row3", d, 32'hA5);
    rd(5'd29, d); chk("R11 row15 width", d, 32'hFF);
    rd(5'd14, d); chk("R11 row0 reset", d, 0);
    chk("R11 wake_mask_o row3", wake[31:24], 8'hA5);
    chk("R11 wake_mask_o row15", wake[127:120], 8'hFF);
  endtask

  task automatic t_order;
    logic [31:0] d;
    wr(5'd0, 32'h1);
    push(snap(1)); push(snap(2));
    rd(5'd1, d);  chk("R5 count 2", d, 32'h20);
    rd(5'd12, d); chk("R3 entA first", d, snap(1)[31:0]);
    rd(5'd12, d); chk("R4 entA no pop", d, snap(1)[31:0]);
    rd(5'd13, d); chk("R3 entB first", d, snap(1)[63:32]);
    rd(5'd1, d);  chk("R4 count after pop", d, 32'h10);
    rd(5'd12, d); chk("R3 entA second", d, snap(2)[31:0]);
    rd(5'd13, d); chk("R3 entB second", d, snap(2)[63:32]);
    rd(5'd12, d); chk("R4 empty entA", d, 0);
    rd(5'd13, d); chk("R4 empty entB", d, 0);
    rd(5'd1, d);  chk("R5 count 0", d, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    for (int k = 0; k < 9; k++) push(snap(10 + k));
    rd(5'd1, d); chk("R6 full+ovf", d, 32'h81);
    wr(5'd1, 32'h0);
    rd(5'd1, d); chk("R8 zero write no effect", d, 32'h81);
    wr(5'd1, 32'h1);
    rd(5'd1, d); chk("R8 ovf cleared", d, 32'h80);
    for (int k = 0; k < 8; k++) begin
      rd(5'd12, d); chk("R6 drain lo", d, snap(10 + k)[31:0]);
      rd(5'd13, d); chk("R6 drain hi", d, snap(10 + k)[63:32]);
    end
    rd(5'd12, d); chk("R6 ninth dropped", d, 0);
  endtask

  task automatic t_threshold;
    logic [31:0] d;
    wr(5'd0, 32'h0000_C009);
    push(snap(30)); push(snap(31));
    @(posedge clk); #1;
    chk("R7 below threshold irq", irq, 0);
    push(snap(32));
    chk("R7 irq not before next edge", irq, 0);
    @(posedge clk); #1;
    chk("R7 irq raised", irq, 1);
    rd(5'd1, d); chk("R7 status", d, 32'h34);
    wr(5'd1, 32'h4);
    rd(5'd1, d); chk("R8 set wins over clear", d, 32'h34);
    for (int k = 0; k < 3; k++) rd(5'd13, d);
    rd(5'd1, d); chk("R7 sticky flag", d, 32'h04);
    wr(5'd1, 32'h4);
    rd(5'd1, d); chk("R8 thr cleared", d, 0);
    chk("R7 irq low after clear", irq, 0);
    wr(5'd0, 32'h0000_C001);
    for (int k = 0; k < 3; k++) push(snap(40 + k));
    @(posedge clk); #1;
    rd(5'd1, d); chk("R7 flag without enable", d, 32'h34);
    chk("R7 irq gated off", irq, 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(5'd0, 32'h0);
    @(posedge clk); #1;
    rd(5'd1, d); chk("R9 flushed count", (d >> 4) & 32'hF, 0);
    push(snap(50));
    wr(5'd0, 32'h1);
    rd(5'd1, d);  chk("R9 ignored while off", (d >> 4) & 32'hF, 0);
    rd(5'd12, d); chk("R9 entA empty", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_control;
    t_delays;
    t_wake;
    t_order;
    t_overflow;
    t_threshold;
    t_disable;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule